// File: doc/BRIEF.md
# UART Receive Word Packer with Stale Flush

This block sits behind a UART byte receiver and gathers incoming bytes into 32-bit words for software. Each byte arrives as a one-cycle strobe on a valid/data input. Bytes go into a packing buffer, with the earliest byte in the least significant lane. When the fourth byte lands, the whole word enters an eight-deep receive word FIFO. Software reads the FIFO one word at a time through a small register port.

Software may not want to wait for a full word. A stale event pushes whatever partial word the packing buffer holds into the FIFO, with the unused upper lanes set to zero. Software can force a stale event with a command. A stale event also fires by itself after a stretch of idle input, unless software has turned that off. Software can read the packing byte count, so it knows how many lanes of a flushed word are valid. Status flags show data ready, stale event and receive overrun. Each flag has its own clear command. A transfer-length register is writable and can be read back, so software can rearm it after each flush.

Top module: `rx_word_packer`

## Requirements
- R1: Bytes are packed four per 32-bit word. The first byte received occupies bits 7:0, the second bits 15:8, the third bits 23:16 and the fourth bits 31:24.
- R2: Register word 0 is status, and its bit 0 is 1 exactly when the FIFO holds at least one word. A read of register word 4 returns the oldest FIFO word and removes it. A read of word 4 with the FIFO empty returns zero and changes no state.
- R3: Register word 2 reports the packing buffer byte count, 0 to 4, in bits 9:7. All its other bits are zero.
- R4: Writing 4 into bits 11:8 of the command register (word 1) forces a stale event. A forced event with 1 to 3 bytes buffered pushes the zero-padded partial word, resets the count and sets status bit 1. A forced event with an empty buffer, or while a full word is held for lack of a FIFO slot, pushes nothing and sets no flag.
- R5: Writing 8 into command bits 7:4 clears status bit 1.
- R6: Automatic stale events are enabled after reset, shown as status bit 2 = 1. With 1 to 3 bytes buffered and STALE_IDLE idle cycles, the block flushes as in R4. Writing 6 into command bits 11:8 disables automatic events, and status bit 2 then reads 0.
- R7: The FIFO holds 8 words. If a word completes while the FIFO is full, the packing buffer keeps it (count 4) and pushes it as soon as a slot frees.
- R8: A byte that arrives with count 4 and the FIFO full is dropped and sets status bit 4. Writing 3 into command bits 7:4 clears status bit 4.
- R9: A byte that arrives in the same cycle as a stale flush starts the next word: it is not part of the flushed word, and the count becomes 1.
- R10: Register word 3 holds a transfer length of XFER_W bits. It reads back what was written, truncated to that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops FIFO at word 4) |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |

## Verification
The two functions that collide here are byte packing and the stale flush. The bench provokes the collision with a write of the force-stale command in the same clock as a byte strobe, while two bytes are already buffered. The scoreboard then expects a zero-padded word that holds only the two earlier bytes, and a packing count of one. The next three bytes must complete a word that starts with the colliding byte. A second collision case lets a FIFO slot free while a held full word and an incoming byte compete. That word must land intact, and the drop and overrun flag must happen only when both the buffer and the FIFO are full.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  typedef enum logic [1:0] {
    PUSH_NONE      = 2'd0,
    PUSH_HELD      = 2'd1,
    PUSH_WITH_BYTE = 2'd2
  } pushMode_e;

  typedef struct packed {
    pushMode_e pushMode;
    logic      loadByte;
    logic      popFifo;
  } dpCtrl_t;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_CMD    = 1;
  localparam int ADDR_RXSTAT = 2;
  localparam int ADDR_XFER   = 3;
  localparam int ADDR_DATA   = 4;

  localparam int RXSTAT_SHIFT = 7;

  localparam logic [3:0] LO_CLR_OVERRUN = 4'd3;
  localparam logic [3:0] LO_CLR_STALE   = 4'd8;
  localparam logic [3:0] HI_FORCE_STALE = 4'd4;
  localparam logic [3:0] HI_AUTO_OFF    = 4'd6;

endpackage

// File: rtl/rxpk_datapath.sv
module rxpk_datapath
  import rxpk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  dpCtrl_t           ctl,
  output logic [CNT_W-1:0]  packCnt,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [WORD_W-1:0] headWord
);

  logic [WORD_W-1:0] packBuf;
  logic [WORD_W-1:0] nextBuf, baseBuf, pushWord, laneByte;
  logic [CNT_W-1:0]  nextCnt, baseCnt;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [OCC_W-1:0]  occ;
  logic              doPush, doPop;

  assign fifoFull  = (occ == OCC_W'(DEPTH));
  assign fifoEmpty = (occ == '0);
  assign doPush    = (ctl.pushMode != PUSH_NONE);
  assign doPop     = ctl.popFifo && !fifoEmpty;
  assign headWord  = fifoEmpty ? '0 : mem[rdPtr];

  always_comb begin
    laneByte = WORD_W'(byteData) << (packCnt * BYTE_W);
    pushWord = (ctl.pushMode == PUSH_WITH_BYTE) ? (packBuf | laneByte) : packBuf;
    baseBuf  = doPush ? '0 : packBuf;
    baseCnt  = doPush ? '0 : packCnt;
    nextBuf  = baseBuf;
    nextCnt  = baseCnt;
    if (ctl.loadByte && ctl.pushMode != PUSH_WITH_BYTE) begin
      nextBuf = baseBuf | (WORD_W'(byteData) << (baseCnt * BYTE_W));
      nextCnt = baseCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packBuf <= '0;
      packCnt <= '0;
    end else begin
      packBuf <= nextBuf;
      packCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushWord;
  end

  AST_FILL_MAX: assert property (@(posedge clk) disable iff (!rstN)
    packCnt <= CNT_W'(LANES)); // R3
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushMode != PUSH_NONE) |-> !fifoFull); // R7
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.popFifo |-> !fifoEmpty); // R2
  AST_HELD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushMode == PUSH_HELD) |=> (packCnt <= CNT_W'(1))); // R9

endmodule

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int XFER_W = 16,
  parameter int STALE_IDLE = 16,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int IDLE_W = $clog2(STALE_IDLE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  packCnt,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic [WORD_W-1:0] headWord,
  output dpCtrl_t           ctl,
  output logic [WORD_W-1:0] regRdData
);

  logic              cmdWr, forceStale, autoFire, flushReq;
  logic              dropByte, stalePush, partial;
  logic              overrunFlag, staleFlag, autoStaleEn;
  logic [IDLE_W-1:0] idleCnt;
  logic [XFER_W-1:0] xferLen;
  logic [3:0]        loCode, hiCode;

  assign loCode     = regWrData[7:4];
  assign hiCode     = regWrData[11:8];
  assign cmdWr      = regWrEn && (regAddr == ADDR_W'(ADDR_CMD));
  assign forceStale = cmdWr && (hiCode == HI_FORCE_STALE);
  assign partial    = (packCnt != '0) && (packCnt != CNT_W'(LANES));
  assign autoFire   = autoStaleEn && partial && (idleCnt >= IDLE_W'(STALE_IDLE));
  assign flushReq   = forceStale || autoFire;

  always_comb begin
    ctl.pushMode = PUSH_NONE;
    ctl.loadByte = 1'b0;
    ctl.popFifo  = regRdEn && (regAddr == ADDR_W'(ADDR_DATA)) && !fifoEmpty;
    dropByte     = 1'b0;
    stalePush    = 1'b0;
    if (packCnt == CNT_W'(LANES)) begin
      if (!fifoFull) begin
        ctl.pushMode = PUSH_HELD;
        ctl.loadByte = byteValid;
      end else begin
        dropByte = byteValid;
      end
    end else if (flushReq && partial && !fifoFull) begin
      ctl.pushMode = PUSH_HELD;
      ctl.loadByte = byteValid;
      stalePush    = 1'b1;
    end else if (byteValid) begin
      ctl.loadByte = 1'b1;
      if (packCnt == CNT_W'(LANES - 1) && !fifoFull) ctl.pushMode = PUSH_WITH_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt     <= '0;
      overrunFlag <= 1'b0;
      staleFlag   <= 1'b0;
      autoStaleEn <= 1'b1;
      xferLen     <= '0;
    end else begin
      if (!autoStaleEn || byteValid || !partial || stalePush) idleCnt <= '0;
      else if (idleCnt < IDLE_W'(STALE_IDLE)) idleCnt <= idleCnt + IDLE_W'(1);

      if (dropByte) overrunFlag <= 1'b1;
      else if (cmdWr && loCode == LO_CLR_OVERRUN) overrunFlag <= 1'b0;

      if (stalePush) staleFlag <= 1'b1;
      else if (cmdWr && loCode == LO_CLR_STALE) staleFlag <= 1'b0;

      if (cmdWr && hiCode == HI_AUTO_OFF) autoStaleEn <= 1'b0;

      if (regWrEn && regAddr == ADDR_W'(ADDR_XFER)) xferLen <= regWrData[XFER_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    case (int'(regAddr))
      ADDR_STATUS: regRdData = WORD_W'({overrunFlag, 1'b0, autoStaleEn, staleFlag, !fifoEmpty});
      ADDR_RXSTAT: regRdData = WORD_W'(packCnt) << RXSTAT_SHIFT;
      ADDR_XFER:   regRdData = WORD_W'(xferLen);
      ADDR_DATA:   regRdData = headWord;
      default:     regRdData = '0;
    endcase
  end

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && packCnt == CNT_W'(LANES) && fifoFull) |=> overrunFlag); // R8
  AST_STALE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (forceStale && partial && !fifoFull) |=> staleFlag); // R4
  AST_AUTO_OFF_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    !autoStaleEn |=> !autoStaleEn); // R6

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rxpk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int ADDR_W = 3,
  parameter int XFER_W = 16,
  parameter int STALE_IDLE = 16,
  localparam int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData
);

  dpCtrl_t           ctl;
  logic [CNT_W-1:0]  packCnt;
  logic              fifoFull, fifoEmpty;
  logic [WORD_W-1:0] headWord;

  rxpk_ctrl #(
    .LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .XFER_W(XFER_W), .STALE_IDLE(STALE_IDLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .packCnt(packCnt), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headWord(headWord),
    .ctl(ctl), .regRdData(regRdData)
  );

  rxpk_datapath #(
    .LANES(LANES), .BYTE_W(BYTE_W), .DEPTH(DEPTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .byteData(byteData), .ctl(ctl),
    .packCnt(packCnt), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headWord(headWord)
  );

endmodule

// File: tb/test_rx_word_packer.sv
module test_rx_word_packer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;
  logic [31:0] expQ[$];

  rx_word_packer i_rx_word_packer (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteData = b;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic writeReg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic byteWithCmd(logic [7:0] b, logic [31:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = b;
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = d;
    @(negedge clk); byteValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #2 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic expectWord(logic [31:0] w);
    expQ.push_back(w);
  endtask

  // monitor: pop one word from the design and compare with the scoreboard head
  task automatic drainOne(string req);
    logic [31:0] got, want;
    readReg(3'd4, got);
    want = (expQ.size() > 0) ? expQ.pop_front() : 32'h0;
    chk(req, got, want);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nFail++;
        nRun++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // reset state
    readReg(3'd0, r); chk("R6 reset status", r, 32'h4);
    readReg(3'd2, r); chk("R3 reset count", r, 32'h0);
    readReg(3'd4, r); chk("R2 empty read", r, 32'h0);
    readReg(3'd0, r); chk("R2 empty read no change", r, 32'h4);

    // automatic stale flush
    sendByte(8'h11); sendByte(8'h22);
    readReg(3'd2, r); chk("R3 count two", r, 32'h100);
    idle(40);
    readReg(3'd2, r); chk("R6 auto flush count", r, 32'h0);
    readReg(3'd0, r); chk("R6 auto flush status", r, 32'h7);
    expectWord(32'h0000_2211); drainOne("R6 auto flush word");

    writeReg(3'd1, 32'h80);
    readReg(3'd0, r); chk("R5 stale clear", r, 32'h4);

    writeReg(3'd1, 32'h600);
    readReg(3'd0, r); chk("R6 auto off", r, 32'h0);
    sendByte(8'h33);
    idle(40);
    readReg(3'd2, r); chk("R6 no flush when off", r, 32'h80);

    // full word packing
    sendByte(8'h44); sendByte(8'h55);
    readReg(3'd2, r); chk("R3 count three", r, 32'h180);
    sendByte(8'h66);
    readReg(3'd0, r); chk("R2 ready", r, 32'h1);
    readReg(3'd2, r); chk("R1 count back to zero", r, 32'h0);
    expectWord(32'h6655_4433); drainOne("R1 lane order");

    // forced flush on empty buffer
    writeReg(3'd1, 32'h400);
    readReg(3'd0, r); chk("R4 empty force no push", r, 32'h0);

    // flush colliding with a byte
    sendByte(8'hA1); sendByte(8'hA2);
    byteWithCmd(8'hA3, 32'h400);
    readReg(3'd2, r); chk("R9 count after collision", r, 32'h80);
    readReg(3'd0, r); chk("R4 stale flag set", r, 32'h3);
    expectWord(32'h0000_A2A1); drainOne("R9 flushed word excludes byte");
    sendByte(8'hA4); sendByte(8'hA5); sendByte(8'hA6);
    expectWord(32'hA6A5_A4A3); drainOne("R9 next word starts with byte");
    writeReg(3'd1, 32'h80);

    sendByte(8'h5C);
    writeReg(3'd1, 32'h400);
    expectWord(32'h0000_005C); drainOne("R4 single byte padded");
    writeReg(3'd1, 32'h80);

    // fill FIFO, hold a word, overrun
    for (int i = 0; i < 32; i++) sendByte(8'h10 + 8'(i));
    for (int k = 0; k < 8; k++)
      expectWord({8'h10 + 8'(4*k+3), 8'h10 + 8'(4*k+2), 8'h10 + 8'(4*k+1), 8'h10 + 8'(4*k)});
    for (int i = 0; i < 4; i++) sendByte(8'hC0 + 8'(i));
    expectWord(32'hC3C2_C1C0);
    readReg(3'd2, r); chk("R7 held word count", r, 32'h200);
    readReg(3'd0, r); chk("R7 ready no overrun", r, 32'h1);
    sendByte(8'hEE);
    readReg(3'd0, r); chk("R8 overrun set", r, 32'h11);
    writeReg(3'd1, 32'h400);
    readReg(3'd2, r); chk("R4 force ignored when held", r, 32'h200);
    readReg(3'd0, r); chk("R4 no stale flag when held", r, 32'h11);
    for (int k = 0; k < 9; k++) drainOne("R7 FIFO order and held push");
    readReg(3'd2, r); chk("R8 dropped byte absent", r, 32'h0);
    writeReg(3'd1, 32'h30);
    readReg(3'd0, r); chk("R8 overrun clear", r, 32'h0);
    readReg(3'd4, r); chk("R2 empty read after drain", r, 32'h0);

    // transfer length register
    writeReg(3'd3, 32'h7);
    readReg(3'd3, r); chk("R10 readback", r, 32'h7);
    writeReg(3'd3, 32'h12345);
    readReg(3'd3, r); chk("R10 truncation", r, 32'h2345);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule